// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block guards writes to a 64K-byte serial memory. It holds the write-enable latch and the protection status byte. For every array write request it decides whether the target address may change. For every status write request it decides whether the status byte may change. The serial shifter in front decodes the commands and passes them in as single-cycle request strobes. The array and its write timer sit behind this block. They use the grant pulses, and the timer reports back through `busy_i`.

The write-enable latch is a two-state machine. `ST_LOCKED` means writes are disabled and `ST_ARMED` means writes are enabled. The transitions are:
- `ARM` goes from `ST_LOCKED` to `ST_ARMED` when an enable request arrives.
- `CONSUME` goes from `ST_ARMED` to `ST_LOCKED` when any status or array write request arrives.
- `HOLD` covers every other case, and the state stays where it is.

Two protect-level bits choose how much of the array is read-only. A protect-enable bit, together with the active-low `wp_n_i` pin, can lock the status byte itself.

Top module: `spi_wp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 while `busy_i` is low, both grant outputs are low and the latch is in `ST_LOCKED`.
- R2: The status byte has this layout: bit0 mirrors `busy_i` combinationally, bit1 is the write-enable latch (1 = armed), bits 3:2 are the protect level and bit7 is protect-enable. Bits 6:4 always read 0.
- R3: An enable request (`wren_i`) accepted on a clock edge sets status bit1 from that edge onward.
- R4: An array write request raises `arr_wr_ok_o` for the one cycle after the request edge only if the latch was armed and the address is outside the protected range. Level 00 protects nothing, 01 protects 0xC000–0xFFFF, 10 protects 0x8000–0xFFFF and 11 protects the whole array.
- R5: A status write request raises `sts_wr_ok_o` for the one cycle after the request edge only if the latch was armed and hardware lock is off. Hardware lock means `wp_n_i` is low and protect-enable is 1. An allowed write copies data bits 7, 3 and 2 into the status byte at that edge.
- R6: Any status or array write request seen while `busy_i` is low returns the latch to `ST_LOCKED`, whether or not it was granted.
- R7: While `wp_n_i` is low and protect-enable is 1, protect-enable stays 1.
- R8: While `busy_i` is high, every request is ignored. No grant is issued and the latch and status bits do not change.
- R9: Requests on the same edge are served in this priority order: status write, then array write, then enable. Only the winner acts, so at most one grant is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Internal write cycle in progress |
| wp_n_i | input | 1 | Active-low write-protect pin |
| wren_i | input | 1 | Write-enable command strobe |
| sts_wr_req_i | input | 1 | Status write command strobe |
| sts_wr_data_i | input | 8 | Data byte for the status write |
| arr_wr_req_i | input | 1 | Array write strobe |
| arr_addr_i | input | ADDR_W | Target array address |
| status_o | output | 8 | Status byte for status reads |
| arr_wr_ok_o | output | 1 | Array write allowed (one-cycle pulse) |
| sts_wr_ok_o | output | 1 | Status write allowed (one-cycle pulse) |

## Verification
The assertions check the following invariants on every cycle:
- the busy bit mirrors `busy_i` and the reserved bits read zero;
- no grant is issued without the latch armed on the request edge;
- no array grant is issued into the protected range;
- no status grant is issued under hardware lock;
- the protect-enable bit is sticky;
- the latch clears after a write request;
- nothing is granted while busy;
- the two grants are never high together.

Only the bench scenarios can show that a grant really appears when it should and that the level decode sits exactly at the 0xBFFF/0xC000 and 0x7FFF/0x8000 boundaries. The same goes for the only-bits-7-3-2 update rule and the priority among requests on one edge. For these the bench runs directed sequences, then a long random mix compared against its own model.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } wel_state_e;

    typedef enum logic [1:0] {
        LVL_NONE    = 2'b00,
        LVL_QUARTER = 2'b01,
        LVL_HALF    = 2'b10,
        LVL_ALL     = 2'b11
    } prot_lvl_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_STATUS,
        OP_ARRAY,
        OP_ARM
    } op_e;

    localparam int unsigned STS_W     = 8;
    localparam int unsigned STS_BUSY  = 0;
    localparam int unsigned STS_WEL   = 1;
    localparam int unsigned STS_LVL_L = 2;
    localparam int unsigned STS_LVL_H = 3;
    localparam int unsigned STS_PE    = 7;

endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  prot_lvl_e         lvl_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o
);
    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (lvl_i)
            LVL_NONE:    hit_o = 1'b0;
            LVL_QUARTER: hit_o = addr_i[TOP] & addr_i[TOP-1];
            LVL_HALF:    hit_o = addr_i[TOP];
            LVL_ALL:     hit_o = 1'b1;
            default:     hit_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_wel_fsm.sv
module wp_wel_fsm
    import wp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic wren_i,
    input  logic sts_req_i,
    input  logic arr_req_i,
    input  logic blk_hit_i,
    input  logic hw_lock_i,
    output logic wel_o,
    output logic sts_commit_o,
    output logic arr_ok_o,
    output logic sts_ok_o
);
    wel_state_e state_q, state_d;
    op_e        op;
    logic       arr_go;

    always_comb begin
        if (busy_i)         op = OP_NONE;
        else if (sts_req_i) op = OP_STATUS;
        else if (arr_req_i) op = OP_ARRAY;
        else if (wren_i)    op = OP_ARM;
        else                op = OP_NONE;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (op == OP_ARM) state_d = ST_ARMED;
            ST_ARMED:  if (op == OP_STATUS || op == OP_ARRAY) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    assign sts_commit_o = (state_q == ST_ARMED) && (op == OP_STATUS) && !hw_lock_i;
    assign arr_go       = (state_q == ST_ARMED) && (op == OP_ARRAY) && !blk_hit_i;
    assign wel_o        = (state_q == ST_ARMED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_ok_o <= 1'b0;
            sts_ok_o <= 1'b0;
        end else begin
            arr_ok_o <= arr_go;
            sts_ok_o <= sts_commit_o;
        end
    end
endmodule

// File: rtl/wp_status_reg.sv
module wp_status_reg
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_i,
    input  logic [STS_W-1:0] wr_data_i,
    output prot_lvl_e        lvl_o,
    output logic             pe_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_o <= LVL_NONE;
            pe_o  <= 1'b0;
        end else if (commit_i) begin
            lvl_o <= prot_lvl_e'(wr_data_i[STS_LVL_H:STS_LVL_L]);
            pe_o  <= wr_data_i[STS_PE];
        end
    end
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              wp_n_i,
    input  logic              wren_i,
    input  logic              sts_wr_req_i,
    input  logic [7:0]        sts_wr_data_i,
    input  logic              arr_wr_req_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    output logic [7:0]        status_o,
    output logic              arr_wr_ok_o,
    output logic              sts_wr_ok_o
);
    prot_lvl_e lvl;
    logic      pe, hw_lock, blk_hit, wel, commit;

    assign hw_lock = !wp_n_i && pe;

    wp_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .lvl_i  (lvl),
        .addr_i (arr_addr_i),
        .hit_o  (blk_hit)
    );

    wp_wel_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .busy_i       (busy_i),
        .wren_i       (wren_i),
        .sts_req_i    (sts_wr_req_i),
        .arr_req_i    (arr_wr_req_i),
        .blk_hit_i    (blk_hit),
        .hw_lock_i    (hw_lock),
        .wel_o        (wel),
        .sts_commit_o (commit),
        .arr_ok_o     (arr_wr_ok_o),
        .sts_ok_o     (sts_wr_ok_o)
    );

    wp_status_reg u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .wr_data_i (sts_wr_data_i),
        .lvl_o     (lvl),
        .pe_o      (pe)
    );

    always_comb begin
        status_o                      = '0;
        status_o[STS_BUSY]            = busy_i;
        status_o[STS_WEL]             = wel;
        status_o[STS_LVL_H:STS_LVL_L] = lvl;
        status_o[STS_PE]              = pe;
    end
endmodule

// File: rtl/spi_wp_ctrl_chk.sv
module spi_wp_ctrl_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic              wp_n_i,
    input logic              sts_wr_req_i,
    input logic              arr_wr_req_i,
    input logic [ADDR_W-1:0] arr_addr_i,
    input logic [7:0]        status_o,
    input logic              arr_wr_ok_o,
    input logic              sts_wr_ok_o
);
    function automatic logic in_prot(input logic [1:0] l, input logic [ADDR_W-1:0] a);
        case (l)
            2'b00:   return 1'b0;
            2'b01:   return a[ADDR_W-1] & a[ADDR_W-2];
            2'b10:   return a[ADDR_W-1];
            default: return 1'b1;
        endcase
    endfunction

    p_busy_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] == busy_i);
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:4] == 3'b000);
    p_arr_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok_o |-> $past(status_o[1]));
    p_arr_outside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_ok_o |-> !in_prot($past(status_o[3:2]), $past(arr_addr_i)));
    p_sts_unlocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sts_wr_ok_o |-> ($past(status_o[1]) && ($past(wp_n_i) || !$past(status_o[7]))));
    p_wel_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && (sts_wr_req_i || arr_wr_req_i)) |=> !status_o[1]);
    p_pe_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n_i && status_o[7]) |=> status_o[7]);
    p_busy_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> (!arr_wr_ok_o && !sts_wr_ok_o));
    p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(status_o[7:1]));
    p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr_ok_o && sts_wr_ok_o));
endmodule

bind spi_wp_ctrl spi_wp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .wp_n_i       (wp_n_i),
    .sts_wr_req_i (sts_wr_req_i),
    .arr_wr_req_i (arr_wr_req_i),
    .arr_addr_i   (arr_addr_i),
    .status_o     (status_o),
    .arr_wr_ok_o  (arr_wr_ok_o),
    .sts_wr_ok_o  (sts_wr_ok_o)
);

// File: tb/tb_spi_wp_ctrl.sv
`timescale 1ns/1ps
module tb_spi_wp_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy_i = 1'b0, wp_n_i = 1'b1, wren_i = 1'b0;
    logic        sts_wr_req_i = 1'b0, arr_wr_req_i = 1'b0;
    logic [7:0]  sts_wr_data_i = '0;
    logic [15:0] arr_addr_i = '0;
    logic [7:0]  status_o;
    logic        arr_wr_ok_o, sts_wr_ok_o;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    logic       m_wel = 1'b0, m_pe = 1'b0;
    logic [1:0] m_lvl = 2'b00;

    always #5 clk = ~clk;

    spi_wp_ctrl dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wp_n_i(wp_n_i),
        .wren_i(wren_i), .sts_wr_req_i(sts_wr_req_i), .sts_wr_data_i(sts_wr_data_i),
        .arr_wr_req_i(arr_wr_req_i), .arr_addr_i(arr_addr_i),
        .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o), .sts_wr_ok_o(sts_wr_ok_o)
    );

    function automatic logic exp_prot(input logic [1:0] l, input logic [15:0] a);
        case (l)
            2'b00:   return 1'b0;
            2'b01:   return a >= 16'hC000;
            2'b10:   return a >= 16'h8000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_pe, 3'b000, m_lvl, m_wel, busy_i};
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
        end
    endtask

    // Drives one request cycle at a falling edge, updates the model at the rising edge,
    // and compares at the next falling edge.
    task automatic step(input string tag, input logic bz, input logic wp, input logic we,
                        input logic sr, input logic [7:0] sd, input logic ar, input logic [15:0] ad);
        logic ea, es;
        busy_i = bz; wp_n_i = wp; wren_i = we;
        sts_wr_req_i = sr; sts_wr_data_i = sd; arr_wr_req_i = ar; arr_addr_i = ad;
        ea = 1'b0; es = 1'b0;
        if (!bz) begin
            if (sr) begin
                if (m_wel && !(!wp && m_pe)) begin
                    es = 1'b1; m_pe = sd[7]; m_lvl = sd[3:2];
                end
                m_wel = 1'b0;
            end else if (ar) begin
                if (m_wel && !exp_prot(m_lvl, ad)) ea = 1'b1;
                m_wel = 1'b0;
            end else if (we) begin
                m_wel = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "status_o", status_o, exp_status());
        check(tag, "arr_wr_ok_o", {7'd0, arr_wr_ok_o}, {7'd0, ea});
        check(tag, "sts_wr_ok_o", {7'd0, sts_wr_ok_o}, {7'd0, es});
        busy_i = 1'b0; wren_i = 1'b0; sts_wr_req_i = 1'b0; arr_wr_req_i = 1'b0;
    endtask

    task automatic arm(input string tag);
        step(tag, 1'b0, wp_n_i, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "status_o", status_o, 8'h00);
        check("R1", "grants", {6'd0, arr_wr_ok_o, sts_wr_ok_o}, 8'h00);

        // R2 busy mirror, R8 busy ignores
        busy_i = 1'b1; #1;
        check("R2", "status_o", status_o, 8'h01);
        step("R8", 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 16'h0);
        step("R8", 1'b1, 1'b1, 1'b0, 1'b1, 8'h8C, 1'b0, 16'h0);

        // R3 arm, R4 level 00 allows everything, R6 consumed
        arm("R3");
        step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'hFFFF);
        step("R6", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0000);

        // R5 status write only bits 7,3,2 ; level 01
        arm("R3");
        step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 1'b0, 16'h0);
        arm("R3");
        step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h04, 1'b0, 16'h0);
        arm("R3"); step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'hBFFF);
        arm("R3"); step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'hC000);
        // level 10
        arm("R3"); step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h08, 1'b0, 16'h0);
        arm("R3"); step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h7FFF);
        arm("R3"); step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h8000);
        // level 11
        arm("R3"); step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h0C, 1'b0, 16'h0);
        arm("R3"); step("R4", 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 16'h0000);

        // R7 protect-enable locked by pin low
        arm("R3"); step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h80, 1'b0, 16'h0);
        arm("R3"); step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 16'h0);
        check("R7", "pe bit", {7'd0, status_o[7]}, 8'h01);
        arm("R3"); step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 16'h0);
        // write without latch denied
        step("R5", 1'b0, 1'b1, 1'b0, 1'b1, 8'h8C, 1'b0, 16'h0);

        // R9 priority
        arm("R3"); step("R9", 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 16'h0000);
        arm("R3"); step("R9", 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b1, 16'h1234);

        // random mix
        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            case ($urandom % 4)
                0: a = 16'hC000 - 16'($urandom % 2);
                1: a = 16'h8000 - 16'($urandom % 2);
                default: ;
            endcase
            d = 8'($urandom);
            step("R4", ($urandom % 8) == 0, ($urandom % 4) != 0, ($urandom % 3) == 0,
                 ($urandom % 6) == 0, d, ($urandom % 3) == 0, a);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule